// File: doc/BRIEF.md
# Clause 22 Management Interface Master

This block drives the two-wire PHY management interface (a clock, MDC, and a bidirectional data line, MDIO) from two 32-bit host registers. One is a control word: an enable, two fault bits that are stored and read back, a 16-bit clock divider, and a read-only idle flag. The other is a command word. Writing the command word with its go bit set runs exactly one read or write frame to a PHY. Go stays high while the frame runs and drops when it ends. For a read, the same word then holds the 16 bits the PHY returned and an acknowledge flag.

The host writes through a plain strobe (`wr_en`) with a one-bit register select. There is no back-pressure on this port. A command write that arrives while go is high is dropped, so software polls go before it issues the next command. Both registers are visible at all times on the two read-back outputs. The MDIO line is split into an output, an output enable and an input, so the pad can be built outside the block.

Top module: `mdio_ctl`

## Requirements
- R1: After reset, the control word reads 0x800000FF: idle (bit 31) is 1, enable (bit 30) is 0, and the divider (bits 15:0) is 0xFF. The command word reads 0. `mdc` and `mdio_oe` are low.
- R2: A control write (`wr_sel`=0) stores enable from bit 30, fault from bit 19, fault enable from bit 18 and the divider from bits 15:0. All of them read back at the same positions. Bit 31 of the control word is read-only and ignores the written value.
- R3: The command word (`wr_sel`=1) has these fields: go in bit 31, write in bit 30 (1 = write, 0 = read), ack in bit 29, register number in bits 25:21, PHY address in bits 20:16 and data in bits 15:0. Bits 28:26 read as 0. An accepted write with go=1 starts one frame. Go stays 1 until that frame ends, and only the end of a frame clears it.
- R4: A command write while go is 1 has no effect on the stored fields or on the frame in progress.
- R5: Every frame is sent MSB first in this order: 32 ones, start bits 01, an opcode (10 for read, 01 for write), the 5-bit PHY address, the 5-bit register number, then two turnaround bits. For a write the turnaround is 10, and it is followed by the 16 data bits of the command word.
- R6: On a read, `mdio_oe` is low for the two turnaround bits and the 16 data bits. When the frame ends, bits 15:0 hold the values sampled on the 16 data rising edges. Ack is 1 only if `mdio_i` was 0 at the rising edge of the second turnaround bit. After a write frame, ack reads 0.
- R7: One MDC period lasts divider+1 clock cycles, with a minimum of 2, so a divider of 0 or 1 gives MDC at half the clock rate. `mdio_o` changes only while MDC is low, and the PHY input is sampled on the MDC rising edge.
- R8: Idle reads 1 when no frame is in progress or enable is 0, and reads 0 while a frame runs.
- R9: A go written while enable is 0 stays pending with no MDC activity, and the frame starts once enable is set. Clearing enable in the middle of a frame abandons it at once: MDC and `mdio_oe` go low and go stays set. When enable is set again, the frame restarts from its first preamble bit.
- R10: MDC is held low whenever idle reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the command word |
| wr_data | input | 32 | Host write data |
| ctrl_word | output | 32 | Control word read-back |
| user_word | output | 32 | Command word read-back, with status |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Output enable for the management data pad |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
If the bit counter is off by one, the frame shifts. The PHY model then decodes a wrong opcode or address, or samples the ack on the wrong turnaround bit, and the error shows when the frame ends, at most 64 MDC periods later. If the divider counter is wrong, the next pair of MDC rising edges shows it in the measured period. If the go/idle bookkeeping is wrong, go either never clears, which hangs the poll, or clears while idle is still 0, which shows within one cycle. Abort and pending-go faults show as MDC edges while disabled, or as a restarted frame that does not begin with a full preamble.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // Bit positions the host software relies on.
  localparam int CTL_IDLE_B = 31;
  localparam int CTL_EN_B   = 30;
  localparam int CTL_FLT_B  = 19;
  localparam int CTL_FEN_B  = 18;
  localparam int CMD_GO_B   = 31;
  localparam int CMD_WR_B   = 30;
  localparam int CMD_REG_LO = 21;
  localparam int CMD_PHY_LO = 16;

  typedef struct packed {
    logic        wr;
    logic [4:0]  rg;
    logic [4:0]  phy;
    logic [15:0] data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] last, half, cnt;
  logic [DIV_W:0]   span;
  logic             mdc_q;
  logic             unused_span;

  // Period is last+1 cycles; a divider of 0 is promoted to 1 so the period stays >= 2.
  assign last        = (div == '0) ? DIV_W'(1) : div;
  assign span        = {1'b0, last} + 1'b1;
  assign half        = span[DIV_W:1];
  assign unused_span = span[0];

  assign rise_stb = run && (cnt == half - 1'b1);
  assign fall_stb = run && (cnt == last);
  assign mdc      = mdc_q & run;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (fall_stb) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (rise_stb) mdc_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        abort,
  input  mdio_cmd_t   cmd,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_i,
  output logic        active,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_data,
  output logic        ack
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int CW        = $clog2(FRAME_LEN);
  localparam int TA0       = PRE_LEN + 14;
  localparam int TA1       = TA0 + 1;
  localparam int DAT0      = PRE_LEN + 16;
  localparam int LAST      = FRAME_LEN - 1;

  logic [CW-1:0] bidx;
  logic [31:0]   tail;
  logic [4:0]    toff;
  logic [15:0]   sh;
  logic          in_pre, rd_release;

  // Everything after the preamble; the read turnaround and data slots are placeholders.
  assign tail = {2'b01,
                 cmd.wr ? 2'b01 : 2'b10,
                 cmd.phy, cmd.rg,
                 cmd.wr ? 2'b10 : 2'b11,
                 cmd.wr ? cmd.data : 16'hFFFF};

  assign in_pre     = (bidx < CW'(PRE_LEN));
  assign toff       = 5'(bidx - CW'(PRE_LEN));
  assign mdio_o     = in_pre ? 1'b1 : tail[5'd31 - toff];
  assign rd_release = !cmd.wr && (bidx >= CW'(TA0));
  assign mdio_oe    = active && !abort && !rd_release;
  assign done       = active && fall_stb && (bidx == CW'(LAST));
  assign rd_data    = sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      bidx   <= '0;
      sh     <= '0;
      ack    <= 1'b0;
    end else if (abort) begin
      active <= 1'b0;
      bidx   <= '0;
    end else if (start) begin
      active <= 1'b1;
      bidx   <= '0;
      ack    <= 1'b0;
    end else if (active) begin
      if (rise_stb) begin
        if (bidx == CW'(TA1)) ack <= ~mdio_i;
        if (bidx >= CW'(DAT0)) sh <= {sh[14:0], mdio_i};
      end
      if (fall_stb) begin
        if (bidx == CW'(LAST)) active <= 1'b0;
        else                   bidx   <= bidx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_ctl.sv
module mdio_ctl
  import mdio_pkg::*;
#(
  parameter int          PRE_LEN   = 32,
  parameter int          DIV_W     = 16,
  parameter logic [15:0] DIV_RESET = 16'h00FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] ctrl_word,
  output logic [31:0] user_word,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic             en_q, flt_q, fen_q, go_q, ack_q;
  logic [DIV_W-1:0] div_q;
  mdio_cmd_t        cmd_q;
  logic             active, done, start, run, rise_stb, fall_stb, f_ack;
  logic [15:0]      rd_data;
  logic [15:0]      div_ext;
  logic             unused_wr;

  assign start     = go_q && en_q && !active;
  assign run       = active && en_q;
  assign div_ext   = 16'(div_q);
  assign unused_wr = ^wr_data[29:26];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      flt_q <= 1'b0;
      fen_q <= 1'b0;
      div_q <= DIV_W'(DIV_RESET);
      go_q  <= 1'b0;
      ack_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      if (wr_en && !wr_sel) begin
        en_q  <= wr_data[CTL_EN_B];
        flt_q <= wr_data[CTL_FLT_B];
        fen_q <= wr_data[CTL_FEN_B];
        div_q <= wr_data[DIV_W-1:0];
      end
      if (wr_en && wr_sel && !go_q) begin
        go_q      <= wr_data[CMD_GO_B];
        ack_q     <= 1'b0;
        cmd_q.wr   <= wr_data[CMD_WR_B];
        cmd_q.rg   <= wr_data[CMD_REG_LO +: 5];
        cmd_q.phy  <= wr_data[CMD_PHY_LO +: 5];
        cmd_q.data <= wr_data[15:0];
      end else if (done) begin
        go_q <= 1'b0;
        if (!cmd_q.wr) begin
          cmd_q.data <= rd_data;
          ack_q      <= f_ack;
        end else begin
          ack_q <= 1'b0;
        end
      end
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div_q),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(!en_q), .cmd(cmd_q),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .mdio_i(mdio_i),
    .active(active), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_data(rd_data), .ack(f_ack)
  );

  assign ctrl_word = {!run, en_q, 10'b0, flt_q, fen_q, 2'b0, div_ext};
  assign user_word = {go_q, cmd_q.wr, ack_q, 3'b0, cmd_q.rg, cmd_q.phy, cmd_q.data};
endmodule

// File: rtl/mdio_ctl_chk.sv
module mdio_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrl_word,
  input logic [31:0] user_word,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  assert_mdc_parked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[31] |-> !mdc);

  assert_oe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[31] |-> !mdio_oe);

  assert_busy_has_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[31] |-> user_word[31]);

  assert_mdo_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_o));

  assert_fields_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    user_word[31] |=> $stable({user_word[30], user_word[25:16]}));

  assert_go_clears_from_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(user_word[31]) |-> $past(!ctrl_word[31]));
endmodule

bind mdio_ctl mdio_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .user_word(user_word),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_ctl_bench.sv
module mdio_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] PHY_ID = 5'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] ctrl_word, user_word;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_ctl u_mdio_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_word(ctrl_word), .user_word(user_word), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model and MDC observer, all at the falling clock edge.
  logic [15:0] phy_mem [32];
  logic [63:0] sh = '0;
  logic        m_rd = 1'b0;
  logic [4:0]  m_phy = '0, m_reg = '0;
  logic        prev_mdc = 1'b0;
  logic        frame_bad = 1'b0, oe_bad = 1'b0;
  int n = 0, cyc = 0, last_rise = 0, last_period = 0, rise_cnt = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mdc && !prev_mdc) begin
      if (n > 0) last_period = cyc - last_rise;
      last_rise = cyc;
      rise_cnt  = rise_cnt + 1;
      if (n >= 46 && m_rd && mdio_oe) oe_bad = 1'b1;
      sh = {sh[62:0], mdio_o};
      n  = n + 1;
      if (n == 32 && sh[31:0] != 32'hFFFF_FFFF) frame_bad = 1'b1;
      if (n == 46) begin
        if (sh[13:12] != 2'b01) frame_bad = 1'b1;
        m_rd = (sh[11:10] == 2'b10);
        if (!m_rd && sh[11:10] != 2'b01) frame_bad = 1'b1;
        m_phy = sh[9:5];
        m_reg = sh[4:0];
      end
      if (n == 48 && !m_rd && sh[1:0] != 2'b10) frame_bad = 1'b1;
      if (n == 64 && !m_rd && m_phy == PHY_ID) phy_mem[m_reg] = sh[15:0];
    end else if (!mdc && prev_mdc) begin
      if (m_rd && m_phy == PHY_ID && n == 47) mdio_i = 1'b0;
      else if (m_rd && m_phy == PHY_ID && n >= 48 && n <= 63) mdio_i = phy_mem[m_reg][63-n];
      else mdio_i = 1'b1;
    end
    if (ctrl_word[31]) begin
      n = 0;
      mdio_i = 1'b1;
    end
    prev_mdc = mdc;
  end

  logic [15:0] exp_mem [32];

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!user_word[31]) break;
    end
  endtask

  function automatic logic [31:0] cmd_word(logic go, logic wr, logic [4:0] rg, logic [4:0] phy, logic [15:0] d);
    return {go, wr, 1'b0, 3'b000, rg, phy, d};
  endfunction

  function automatic logic [31:0] exp_after(logic wr, logic [4:0] rg, logic [4:0] phy, logic [15:0] d);
    logic ackb;
    logic [15:0] dv;
    ackb = !wr && (phy == PHY_ID);
    dv   = wr ? d : (ackb ? exp_mem[rg] : 16'hFFFF);
    return {1'b0, wr, ackb, 3'b000, rg, phy, dv};
  endfunction

  task automatic run_op(input logic wr, input logic [4:0] rg, input logic [4:0] phy, input logic [15:0] d, input string req);
    logic [31:0] e;
    host_wr(1'b1, cmd_word(1'b1, wr, rg, phy, d));
    wait_done();
    e = exp_after(wr, rg, phy, d);
    check(user_word == e, req, user_word, e);
    if (wr && phy == PHY_ID) exp_mem[rg] = d;
  endtask

  initial begin
    for (int i = 0; i < CLK_PERIOD * 150000; i += CLK_PERIOD) #(CLK_PERIOD);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed_v;
    int r0;
    seed_v = 7;
    r0 = $urandom(seed_v);
    for (int i = 0; i < 32; i++) begin
      phy_mem[i] = 16'(i * 16'h0101 + 16'h1357);
      exp_mem[i] = phy_mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ctrl_word == 32'h8000_00FF, "R1 ctrl reset", ctrl_word, 32'h8000_00FF);
    check(user_word == 32'h0, "R1 cmd reset", user_word, 32'h0);
    check(!mdc && !mdio_oe, "R1 pins low", {30'b0, mdc, mdio_oe}, 32'h0);

    // R2 field readback, idle read-only
    host_wr(1'b0, 32'h000C_0005);
    check(ctrl_word == 32'h800C_0005, "R2 ctrl fields", ctrl_word, 32'h800C_0005);
    host_wr(1'b0, 32'h4000_0002);
    check(ctrl_word == 32'hC000_0002, "R2 enable div", ctrl_word, 32'hC000_0002);

    // R3/R4/R5/R7/R8 directed write at div 2
    host_wr(1'b1, cmd_word(1'b1, 1'b1, 5'd1, PHY_ID, 16'hA5A5));
    repeat (3) @(negedge clk);
    check(user_word[31] == 1'b1, "R3 go held", {31'b0, user_word[31]}, 32'h1);
    check(ctrl_word[31] == 1'b0, "R8 busy idle", {31'b0, ctrl_word[31]}, 32'h0);
    host_wr(1'b1, cmd_word(1'b1, 1'b0, 5'd9, 5'd9, 16'h0000));
    wait_done();
    check(user_word == exp_after(1'b1, 5'd1, PHY_ID, 16'hA5A5), "R4 busy write dropped",
          user_word, exp_after(1'b1, 5'd1, PHY_ID, 16'hA5A5));
    exp_mem[1] = 16'hA5A5;
    check(phy_mem[1] == 16'hA5A5, "R5 write delivered", {16'b0, phy_mem[1]}, 32'h0000_A5A5);
    check(!frame_bad, "R5 frame format", {31'b0, frame_bad}, 32'h0);
    check(last_period == 3, "R7 period div2", last_period, 3);
    @(negedge clk);
    check(ctrl_word[31] == 1'b1, "R8 idle after", {31'b0, ctrl_word[31]}, 32'h1);

    // R6 read back and no-ack read
    run_op(1'b0, 5'd1, PHY_ID, 16'h0000, "R6 read ack data");
    check(!oe_bad, "R6 oe released", {31'b0, oe_bad}, 32'h0);
    run_op(1'b0, 5'd4, 5'd20, 16'h0000, "R6 no ack");

    // R7 divider 0
    host_wr(1'b0, 32'h4000_0000);
    run_op(1'b0, 5'd7, PHY_ID, 16'h0000, "R6 read div0");
    check(last_period == 2, "R7 period div0", last_period, 2);

    // Random mix
    for (int k = 0; k < 40; k++) begin
      logic wr;
      logic [4:0] rg, phy;
      logic [15:0] d;
      host_wr(1'b0, 32'h4000_0000 | ($urandom % 4));
      wr  = 1'($urandom);
      rg  = 5'($urandom);
      phy = ($urandom % 3 == 0) ? 5'($urandom) : PHY_ID;
      d   = 16'($urandom);
      run_op(wr, rg, phy, d, wr ? "R5 random write" : "R6 random read");
    end
    check(!frame_bad && !oe_bad, "R5 random frames", {30'b0, frame_bad, oe_bad}, 32'h0);

    // R9 pending go while disabled
    host_wr(1'b0, 32'h0000_0001);
    begin
      int rc;
      rc = rise_cnt;
      host_wr(1'b1, cmd_word(1'b1, 1'b0, 5'd1, PHY_ID, 16'h0));
      repeat (50) @(negedge clk);
      check(user_word[31] && ctrl_word[31] && rise_cnt == rc, "R9 pending go",
            {user_word[31], ctrl_word[31], 30'(rise_cnt - rc)}, 32'hC000_0000);
    end
    host_wr(1'b0, 32'h4000_0001);
    wait_done();
    check(user_word == exp_after(1'b0, 5'd1, PHY_ID, 16'h0), "R9 pending completes",
          user_word, exp_after(1'b0, 5'd1, PHY_ID, 16'h0));

    // R9 abort and restart
    host_wr(1'b1, cmd_word(1'b1, 1'b1, 5'd5, PHY_ID, 16'h1234));
    repeat (40) @(negedge clk);
    host_wr(1'b0, 32'h0000_0001);
    check(ctrl_word[31] && !mdc && !mdio_oe && user_word[31], "R9 abort",
          {ctrl_word[31], mdc, mdio_oe, user_word[31], 28'b0}, 32'h9000_0000);
    check(!mdc, "R10 parked on abort", {31'b0, mdc}, 32'h0);
    host_wr(1'b0, 32'h4000_0001);
    wait_done();
    exp_mem[5] = 16'h1234;
    check(phy_mem[5] == 16'h1234 && !frame_bad, "R9 restart full frame",
          {15'b0, frame_bad, phy_mem[5]}, 32'h0000_1234);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule